// File: doc/BRIEF.md
# Channel Select and Display Controller

This block is the front-panel logic of a temperature-tuned laser channel selector. It holds the active channel number (one of eight) and drives the indicators that show the operator what the loop is doing. The starting channel is read from a 3-bit DIP switch while reset is asserted. After that the switch is no longer looked at, and the channel moves only through two push buttons: one steps up, the other steps down. Both buttons are debounced inside the block.

Every accepted press produces a one-cycle retune request toward the wavelength lock controller, which then returns to coarse tuning. The display side has three outputs: a BCD digit for an external 7-segment decoder, a blanking control, and a temperature-lock LED. Right after reset the digit shows 8 as a lamp test. It then shows the channel. Until the laser temperature has settled, the digit blinks at a prescaled rate. The LED comes on when the temperature-locked input rises and goes dark again when a retune is requested.

Top module: `chansel_panel`

## Requirements
- R1: While `rst` is high the channel is loaded from `dip_sw` as a binary number, with `dip_sw[0]` (switch position 1) as the least significant bit.
- R2: Changes on `dip_sw` after reset is released leave the channel unchanged.
- R3: An accepted press on `btn_up` raises the channel by one, and channel 7 goes to 0.
- R4: An accepted press on `btn_dn` lowers the channel by one, and channel 0 goes to 7.
- R5: A button counts as pressed only after its synchronised level has been high for `DEB_CYCLES` consecutive cycles. A shorter pulse does nothing, and a held press gives exactly one step.
- R6: Each accepted press makes `retune_req` high for exactly one cycle, on the same clock edge at which `chan` takes its new value. `chan` does not change at any other time.
- R7: If both buttons are accepted in the same cycle, the channel stays the same and a single retune request is still raised.
- R8: For `LAMP_CYCLES` cycles after reset, `bcd_digit` is 8 and `digit_blank` is 0.
- R9: After the lamp test, `bcd_digit` equals the channel number. While the temperature is unsettled, `digit_blank` alternates with `BLINK_HALF` cycles on and `BLINK_HALF` cycles off.
- R10: `temp_led` rises in the cycle after `temp_locked` is seen high and stays high until the cycle after a retune request, which clears it even when `temp_locked` is high at the same time. While `temp_led` is high the digit is not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dip_sw | input | 3 | Initial channel switch, bit 0 = position 1 |
| btn_up | input | 1 | Raw channel-up button, high when pressed |
| btn_dn | input | 1 | Raw channel-down button, high when pressed |
| temp_locked | input | 1 | Laser temperature has settled |
| chan | output | 3 | Active channel |
| retune_req | output | 1 | One-cycle request to restart coarse tuning |
| bcd_digit | output | 4 | BCD digit to the segment decoder |
| digit_blank | output | 1 | 1 blanks the display |
| temp_led | output | 1 | Temperature-lock indicator |

## Verification
A retune request and an asserted `temp_locked` can arrive in the same cycle. In that case the LED must show the clear, because the restart of coarse tuning has priority. The bench provokes this by holding `temp_locked` high throughout and pressing a button. It then judges the two samples after the request: the LED must be low on the first and high again on the second. A second coincidence is both buttons accepted together, which the bench drives with identical timing and judges by one request with an unchanged channel.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

    localparam int NUM_CH = 8;
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [3:0] LAMP_DIGIT = 4'd8;

    typedef logic [CH_W-1:0] chan_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

    typedef struct packed {
        logic [3:0] digit;
        logic       blank;
    } disp_s;

    function automatic step_e step_of(logic up, logic dn);
        if (up && !dn) return STEP_UP;
        if (dn && !up) return STEP_DOWN;
        return STEP_HOLD;
    endfunction

    function automatic chan_t next_chan(chan_t c, step_e s);
        chan_t r;
        case (s)
            STEP_UP:   r = (c == chan_t'(NUM_CH - 1)) ? '0 : c + chan_t'(1);
            STEP_DOWN: r = (c == '0) ? chan_t'(NUM_CH - 1) : c - chan_t'(1);
            default:   r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chansel_debounce.sv
module chansel_debounce #(
    parameter int DEB_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            press  <= 1'b0;
            if (sync_q[1] != stable_q) begin
                if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                    stable_q <= sync_q[1];
                    cnt_q    <= '0;
                    press    <= sync_q[1];
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R5: a held press produces a single pulse
    assert_single_press_R5: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);

endmodule

// File: rtl/chansel_stepper.sv
module chansel_stepper
    import chansel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  chan_t dip,
    input  logic  inc_p,
    input  logic  dec_p,
    output chan_t chan,
    output logic  req
);
    step_e step;

    always_comb step = step_of(inc_p, dec_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan <= dip;
            req  <= 1'b0;
        end else begin
            chan <= next_chan(chan, step);
            req  <= inc_p | dec_p;
        end
    end

    assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    assert_chan_moves_with_req_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan) |-> req);

    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(inc_p) && !$past(dec_p) && $past(chan) == chan_t'(NUM_CH - 1)) |-> chan == '0);

    assert_wrap_down_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(dec_p) && !$past(inc_p) && $past(chan) == '0) |-> chan == chan_t'(NUM_CH - 1));

endmodule

// File: rtl/chansel_display.sv
module chansel_display
    import chansel_pkg::*;
#(
    parameter int BLINK_HALF  = 12500000,
    parameter int LAMP_CYCLES = 25000000
) (
    input  logic  clk,
    input  logic  rst,
    input  chan_t chan,
    input  logic  req,
    input  logic  temp_locked,
    output disp_s disp,
    output logic  led
);
    localparam int BW = $clog2(BLINK_HALF + 1);
    localparam int LW = $clog2(LAMP_CYCLES + 1);

    logic [BW-1:0] blink_cnt_q;
    logic          phase_off_q;
    logic [LW-1:0] lamp_cnt_q;
    logic          lamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            blink_cnt_q <= '0;
            phase_off_q <= 1'b0;
        end else if (blink_cnt_q == BW'(BLINK_HALF - 1)) begin
            blink_cnt_q <= '0;
            phase_off_q <= !phase_off_q;
        end else begin
            blink_cnt_q <= blink_cnt_q + BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                lamp_cnt_q <= LW'(LAMP_CYCLES);
        else if (lamp_cnt_q != '0) lamp_cnt_q <= lamp_cnt_q - LW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              led <= 1'b0;
        else if (req)         led <= 1'b0;
        else if (temp_locked) led <= 1'b1;
    end

    always_comb begin
        lamp       = (lamp_cnt_q != '0);
        disp.digit = lamp ? LAMP_DIGIT : 4'(chan);
        disp.blank = !lamp && !led && phase_off_q;
    end

    assert_lamp_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (disp.digit == LAMP_DIGIT && !disp.blank));

    assert_led_cleared_by_req_R10: assert property (@(posedge clk) disable iff (rst)
        req |=> !led);

    assert_led_set_by_lock_R10: assert property (@(posedge clk) disable iff (rst)
        (temp_locked && !req) |=> led);

endmodule

// File: rtl/chansel_panel.sv
module chansel_panel
    import chansel_pkg::*;
#(
    parameter int DEB_CYCLES  = 50000,
    parameter int BLINK_HALF  = 12500000,
    parameter int LAMP_CYCLES = 25000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] dip_sw,
    input  logic       btn_up,
    input  logic       btn_dn,
    input  logic       temp_locked,
    output logic [2:0] chan,
    output logic       retune_req,
    output logic [3:0] bcd_digit,
    output logic       digit_blank,
    output logic       temp_led
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] raw_btn;
    logic [NBTN-1:0] press;
    chan_t           chan_w;
    disp_s           disp;

    assign raw_btn = {btn_dn, btn_up};

    for (genvar g = 0; g < NBTN; g++) begin : g_deb
        chansel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_btn[g]),
            .press(press[g])
        );
    end

    chansel_stepper u_step (
        .clk  (clk),
        .rst  (rst),
        .dip  (chan_t'(dip_sw)),
        .inc_p(press[0]),
        .dec_p(press[1]),
        .chan (chan_w),
        .req  (retune_req)
    );

    chansel_display #(.BLINK_HALF(BLINK_HALF), .LAMP_CYCLES(LAMP_CYCLES)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .chan       (chan_w),
        .req        (retune_req),
        .temp_locked(temp_locked),
        .disp       (disp),
        .led        (temp_led)
    );

    assign chan        = 3'(chan_w);
    assign bcd_digit   = disp.digit;
    assign digit_blank = disp.blank;

    assert_lit_not_blank_R10: assert property (@(posedge clk) disable iff (rst)
        temp_led |-> !digit_blank);

endmodule

// File: tb/test_chansel_panel.sv
module test_chansel_panel;
    localparam int DEB   = 4;
    localparam int HALF  = 8;
    localparam int LAMP  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] dip_sw = 3'd0;
    logic       btn_up = 1'b0;
    logic       btn_dn = 1'b0;
    logic       temp_locked = 1'b0;
    logic [2:0] chan;
    logic       retune_req;
    logic [3:0] bcd_digit;
    logic       digit_blank;
    logic       temp_led;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = !clk;

    chansel_panel #(.DEB_CYCLES(DEB), .BLINK_HALF(HALF), .LAMP_CYCLES(LAMP)) i_chansel_panel (
        .clk(clk), .rst(rst), .dip_sw(dip_sw), .btn_up(btn_up), .btn_dn(btn_dn),
        .temp_locked(temp_locked), .chan(chan), .retune_req(retune_req),
        .bcd_digit(bcd_digit), .digit_blank(digit_blank), .temp_led(temp_led)
    );

    always @(negedge clk) begin
        if (!rst && retune_req) pulses++;
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] d);
        rst = 1'b1;
        dip_sw = d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic press(input logic up, input logic dn, output int np);
        int p0;
        p0 = pulses;
        btn_up = up;
        btn_dn = dn;
        repeat (DEB + 6) @(negedge clk);
        btn_up = 1'b0;
        btn_dn = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        np = pulses - p0;
    endtask

    initial begin
        int np;
        int exp_ch;
        int blanks;
        // R1, R2, R8: every DIP value at reset, then a later switch change
        for (int d = 0; d < 8; d++) begin
            do_reset(3'(d));
            check(bcd_digit == 4'd8 && !digit_blank, "R8 lamp digit", bcd_digit, 8);
            check(chan == 3'(d), "R1 initial channel", chan, d);
            check(!temp_led, "R10 led at reset", temp_led, 0);
            dip_sw = ~3'(d);
            repeat (LAMP + 3) @(negedge clk);
            check(chan == 3'(d), "R2 dip ignored", chan, d);
            check(bcd_digit == 4'(d), "R9 digit shows channel", bcd_digit, d);
        end

        // R9: blink duty over two whole periods
        do_reset(3'd0);
        repeat (LAMP + 2) @(negedge clk);
        blanks = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            if (digit_blank) blanks++;
            @(negedge clk);
        end
        check(blanks == 2 * HALF, "R9 blink duty", blanks, 2 * HALF);

        // R3, R6: up sweep with wrap
        exp_ch = 0;
        for (int i = 0; i < 8; i++) begin
            press(1'b1, 1'b0, np);
            exp_ch = (exp_ch + 1) % 8;
            check(chan == 3'(exp_ch), "R3 step up", chan, exp_ch);
            check(np == 1, "R6 one request per press", np, 1);
        end

        // R4, R6: down sweep with wrap
        for (int i = 0; i < 8; i++) begin
            press(1'b0, 1'b1, np);
            exp_ch = (exp_ch + 7) % 8;
            check(chan == 3'(exp_ch), "R4 step down", chan, exp_ch);
            check(np == 1, "R6 one request per press", np, 1);
        end

        // R5: short glitch is ignored
        np = pulses;
        btn_up = 1'b1;
        repeat (2) @(negedge clk);
        btn_up = 1'b0;
        repeat (DEB + 8) @(negedge clk);
        check(pulses == np, "R5 glitch rejected", pulses - np, 0);
        check(chan == 3'(exp_ch), "R5 channel kept", chan, exp_ch);

        // R7: both buttons together
        press(1'b1, 1'b1, np);
        check(np == 1, "R7 single request", np, 1);
        check(chan == 3'(exp_ch), "R7 channel kept", chan, exp_ch);

        // R10: temperature settles, blinking stops
        temp_locked = 1'b1;
        repeat (2) @(negedge clk);
        check(temp_led, "R10 led lit", temp_led, 1);
        blanks = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            if (digit_blank) blanks++;
            @(negedge clk);
        end
        check(blanks == 0, "R10 no blink when settled", blanks, 0);

        // R10: request and lock in the same cycle, request wins
        btn_up = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (retune_req) break;
        end
        check(retune_req, "R6 request seen", retune_req, 1);
        @(negedge clk);
        check(!temp_led, "R10 led cleared by request", temp_led, 0);
        @(negedge clk);
        check(temp_led, "R10 led relit", temp_led, 1);
        btn_up = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        exp_ch = (exp_ch + 1) % 8;
        check(chan == 3'(exp_ch), "R3 step while locked", chan, exp_ch);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule